// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides, for each of the two ALU operands of a pipelined processor's execute stage, where the operand value should come from. It looks at the two source register indices of the instruction now entering execute and at the destination indices and write-enables of the two older instructions still in flight: one just past execute, one about to write back. When an older instruction is about to write a register that the current instruction reads, the matching operand is taken from that instruction's pipeline register instead of the register file. The newest producer wins.

Register 0 is a constant zero and never triggers forwarding. A small register file comes with the unit. It has one write port, driven by the writeback stage, and two read ports. A read of a register in the same cycle that register is written returns the value being written, so an instruction three slots behind its producer needs no forwarding path.

Top module: `fwd_unit`

## Requirements
- R1: `sel_a` is 2'b10 (take the post-execute result) when `exm_we` is 1, `exm_rd` is nonzero and `exm_rd` equals `ex_rs`.
- R2: `sel_a` is 2'b01 (take the writeback result) when `mwb_we` is 1, `mwb_rd` is nonzero, `mwb_rd` equals `ex_rs`, and the R1 condition is false.
- R3: `sel_b` follows the rules of R1 and R2 with `ex_rt` in place of `ex_rs`, independently of `sel_a`.
- R4: When both stages match the same source, the select is 2'b10: the post-execute stage has priority.
- R5: A destination index of 0 never causes forwarding, even with its write-enable high.
- R6: A stage whose write-enable is 0 never causes forwarding, even with a matching destination.
- R7: With no qualifying match, the select is 2'b00 (register file).
- R8: A register-file read of a nonzero register being written in the same cycle returns `rf_wdata` in that cycle.
- R9: Reading register 0 always returns zero, and a write to register 0 has no effect.
- R10: After reset every register reads zero, and a written value is returned by later reads until it is overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register file |
| rst_n | input | 1 | Active-low synchronous reset, clears the register file |
| ex_rs | input | 5 | First source index of the instruction entering execute |
| ex_rt | input | 5 | Second source index of the instruction entering execute |
| exm_we | input | 1 | Post-execute instruction writes a register |
| exm_rd | input | 5 | Post-execute instruction destination index |
| mwb_we | input | 1 | Writeback instruction writes a register |
| mwb_rd | input | 5 | Writeback instruction destination index |
| sel_a | output | 2 | Operand A source: 00 file, 10 post-execute, 01 writeback |
| sel_b | output | 2 | Operand B source, same encoding |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 5 | Register file write index |
| rf_wdata | input | 32 | Register file write data |
| rf_raddr_a | input | 5 | Read port A index |
| rf_raddr_b | input | 5 | Read port B index |
| rf_rdata_a | output | 32 | Read port A data |
| rf_rdata_b | output | 32 | Read port B data |

## Verification
The clocked properties assume that the index and enable inputs are settled by the time of each rising edge, because the select outputs are purely combinational. They also assume that reset is held long enough to clear the whole register file before the first read is judged. The stimulus changes all inputs only on the falling edge and keeps reset asserted for several cycles. The match table covers every combination of enable, zero destination and source overlap, so each property's precondition is reached from both sides.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_MWB = 2'b01,
      SEL_EXM = 2'b10
   } fwd_sel_e;

   localparam int unsigned N_OPND = 2;
   localparam int unsigned N_STG  = 2;
endpackage

// File: rtl/fwd_cmp.sv
module fwd_cmp #(
   parameter int unsigned AW        = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic          we,
   input  logic [AW-1:0] dst,
   input  logic [AW-1:0] src,
   output logic          hit
);
   generate
      if (AW < 1) begin : g_bad_aw
         $error("fwd_cmp: AW must be at least 1");
      end
      if (ZERO_HARD) begin : g_zero_excl
         always_comb hit = we && (dst != '0) && (dst == src);
      end else begin : g_zero_incl
         always_comb hit = we && (dst == src);
      end
   endgenerate
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
   import fwd_pkg::*;
(
   input  logic     hit_exm,
   input  logic     hit_mwb,
   output fwd_sel_e sel
);
   always_comb begin
      if (hit_exm)      sel = SEL_EXM;
      else if (hit_mwb) sel = SEL_MWB;
      else              sel = SEL_RF;
   end
endmodule

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
   parameter int unsigned AW        = 5,
   parameter int unsigned DW        = 32,
   parameter int unsigned NRP       = 2,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr [NRP],
   output logic [DW-1:0] rdata [NRP]
);
   localparam int unsigned NREGS = 1 << AW;

   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("fwd_regfile: AW out of range 1..8");
      end
      if (DW < 1) begin : g_bad_dw
         $error("fwd_regfile: DW must be positive");
      end
      if (NRP < 1) begin : g_bad_nrp
         $error("fwd_regfile: NRP must be positive");
      end
   endgenerate

   logic [DW-1:0] mem [NREGS];
   logic          wr_ok;

   always_comb wr_ok = we && (!ZERO_HARD || waddr != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) mem[i] <= '0;
      end else if (wr_ok) begin
         mem[waddr] <= wdata;
      end
   end

   generate
      for (genvar p = 0; p < NRP; p++) begin : g_rd
         always_comb begin
            if (ZERO_HARD && raddr[p] == '0)
               rdata[p] = '0;
            else if (wr_ok && waddr == raddr[p])
               rdata[p] = wdata;
            else
               rdata[p] = mem[raddr[p]];
         end
      end
   endgenerate
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned AW        = 5,
   parameter int unsigned DW        = 32,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ex_rs,
   input  logic [AW-1:0] ex_rt,
   input  logic          exm_we,
   input  logic [AW-1:0] exm_rd,
   input  logic          mwb_we,
   input  logic [AW-1:0] mwb_rd,
   output logic [1:0]    sel_a,
   output logic [1:0]    sel_b,
   input  logic          rf_we,
   input  logic [AW-1:0] rf_waddr,
   input  logic [DW-1:0] rf_wdata,
   input  logic [AW-1:0] rf_raddr_a,
   input  logic [AW-1:0] rf_raddr_b,
   output logic [DW-1:0] rf_rdata_a,
   output logic [DW-1:0] rf_rdata_b
);
   logic [AW-1:0] src     [N_OPND];
   logic          hit_exm [N_OPND];
   logic          hit_mwb [N_OPND];
   fwd_sel_e      sel     [N_OPND];

   always_comb begin
      src[0] = ex_rs;
      src[1] = ex_rt;
   end

   generate
      for (genvar o = 0; o < N_OPND; o++) begin : g_opnd
         fwd_cmp #(.AW(AW), .ZERO_HARD(ZERO_HARD)) u_cmp_exm (
            .we(exm_we), .dst(exm_rd), .src(src[o]), .hit(hit_exm[o]));
         fwd_cmp #(.AW(AW), .ZERO_HARD(ZERO_HARD)) u_cmp_mwb (
            .we(mwb_we), .dst(mwb_rd), .src(src[o]), .hit(hit_mwb[o]));
         fwd_pick u_pick (
            .hit_exm(hit_exm[o]), .hit_mwb(hit_mwb[o]), .sel(sel[o]));
      end
   endgenerate

   always_comb begin
      sel_a = sel[0];
      sel_b = sel[1];
   end

   logic [AW-1:0] rd_idx [2];
   logic [DW-1:0] rd_val [2];

   always_comb begin
      rd_idx[0] = rf_raddr_a;
      rd_idx[1] = rf_raddr_b;
   end

   fwd_regfile #(.AW(AW), .DW(DW), .NRP(2), .ZERO_HARD(ZERO_HARD)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr),
      .wdata(rf_wdata), .raddr(rd_idx), .rdata(rd_val));

   always_comb begin
      rf_rdata_a = rd_val[0];
      rf_rdata_b = rd_val[1];
   end

   // R1 / R4: post-execute match selects the newest result
   a_r1_exm_a: assert property (@(posedge clk) disable iff (!rst_n)
      (exm_we && exm_rd != '0 && exm_rd == ex_rs) |-> sel_a == 2'b10);
   // R2: writeback match without a newer match
   a_r2_mwb_a: assert property (@(posedge clk) disable iff (!rst_n)
      (mwb_we && mwb_rd != '0 && mwb_rd == ex_rs &&
       !(exm_we && exm_rd == ex_rs)) |-> sel_a == 2'b01);
   // R3: operand B uses the second source
   a_r3_exm_b: assert property (@(posedge clk) disable iff (!rst_n)
      (exm_we && exm_rd != '0 && exm_rd == ex_rt) |-> sel_b == 2'b10);
   // R5 / R6: nothing eligible means no forwarding
   a_r5_no_src: assert property (@(posedge clk) disable iff (!rst_n)
      ((!exm_we || exm_rd == '0) && (!mwb_we || mwb_rd == '0))
      |-> (sel_a == 2'b00 && sel_b == 2'b00));
   // select codes are always one of the three legal values
   a_r7_legal: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_a) && $onehot0(sel_b));
   // R8: same-cycle write is visible on a read of that index
   a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && rf_waddr != '0 && rf_waddr == rf_raddr_a)
      |-> rf_rdata_a == rf_wdata);
   // R9: register 0 reads zero
   a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_raddr_b == '0) |-> rf_rdata_b == '0);
   // R10: a write is held for the next read of the same index
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && rf_waddr != '0 && rf_waddr == rf_raddr_a)
      ##1 (rf_raddr_a == $past(rf_waddr) && !rf_we)
      |-> rf_rdata_a == $past(rf_wdata));
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  ex_rs = '0, ex_rt = '0, exm_rd = '0, mwb_rd = '0;
   logic        exm_we = 1'b0, mwb_we = 1'b0;
   logic [1:0]  sel_a, sel_b;
   logic        rf_we = 1'b0;
   logic [4:0]  rf_waddr = '0, rf_raddr_a = '0, rf_raddr_b = '0;
   logic [31:0] rf_wdata = '0;
   logic [31:0] rf_rdata_a, rf_rdata_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   fwd_unit u_dut (
      .clk(clk), .rst_n(rst_n), .ex_rs(ex_rs), .ex_rt(ex_rt),
      .exm_we(exm_we), .exm_rd(exm_rd), .mwb_we(mwb_we), .mwb_rd(mwb_rd),
      .sel_a(sel_a), .sel_b(sel_b), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata), .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
      .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b));

   // {rs, rt, exm_we, exm_rd, mwb_we, mwb_rd, expected sel_a, expected sel_b}
   localparam int NV = 12;
   localparam logic [25:0] VEC [NV] = '{
      {5'd1,  5'd2,  1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00}, // R7
      {5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00}, // R1
      {5'd3,  5'd4,  1'b1, 5'd4,  1'b0, 5'd0,  2'b00, 2'b10}, // R3
      {5'd3,  5'd4,  1'b0, 5'd0,  1'b1, 5'd3,  2'b01, 2'b00}, // R2
      {5'd3,  5'd4,  1'b0, 5'd0,  1'b1, 5'd4,  2'b00, 2'b01}, // R3
      {5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 5'd7,  2'b10, 2'b10}, // R4
      {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}, // R5
      {5'd3,  5'd4,  1'b0, 5'd3,  1'b0, 5'd4,  2'b00, 2'b00}, // R6
      {5'd3,  5'd4,  1'b1, 5'd4,  1'b1, 5'd3,  2'b01, 2'b10}, // R2 R3
      {5'd9,  5'd9,  1'b0, 5'd9,  1'b1, 5'd9,  2'b01, 2'b01}, // R6 R2
      {5'd5,  5'd6,  1'b1, 5'd0,  1'b1, 5'd5,  2'b01, 2'b00}, // R5 R2
      {5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 5'd30, 2'b10, 2'b01}  // R1 R3
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (40) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R10: reset state
      rf_raddr_a = 5'd5; rf_raddr_b = 5'd31;
      #1 chk("R10 reset a", rf_rdata_a, 32'h0);
      chk("R10 reset b", rf_rdata_b, 32'h0);
      chk("R7 reset sel", {30'd0, sel_a}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {ex_rs, ex_rt, exm_we, exm_rd, mwb_we, mwb_rd} = VEC[i][25:4];
         #1;
         chk($sformatf("R1-group vec%0d sel_a", i), {30'd0, sel_a}, {30'd0, VEC[i][3:2]});
         chk($sformatf("R3 vec%0d sel_b", i), {30'd0, sel_b}, {30'd0, VEC[i][1:0]});
      end

      // R8: same-cycle bypass, other port unaffected
      @(negedge clk);
      rf_we = 1'b1; rf_waddr = 5'd5; rf_wdata = 32'hCAFE_0005;
      rf_raddr_a = 5'd5; rf_raddr_b = 5'd6;
      #1 chk("R8 bypass", rf_rdata_a, 32'hCAFE_0005);
      chk("R8 other index", rf_rdata_b, 32'h0);
      // R10: value held after the write edge
      @(negedge clk);
      rf_we = 1'b0; rf_wdata = 32'h1111_1111;
      #1 chk("R10 hold", rf_rdata_a, 32'hCAFE_0005);
      // R9: write to register 0 ignored
      @(negedge clk);
      rf_we = 1'b1; rf_waddr = 5'd0; rf_wdata = 32'hFFFF_FFFF;
      rf_raddr_a = 5'd0; rf_raddr_b = 5'd0;
      #1 chk("R9 zero during write", rf_rdata_a, 32'h0);
      @(negedge clk);
      rf_we = 1'b0;
      #1 chk("R9 zero after write", rf_rdata_b, 32'h0);
      // R10: overwrite, then read on port B
      @(negedge clk);
      rf_we = 1'b1; rf_waddr = 5'd5; rf_wdata = 32'h0BAD_F00D;
      @(negedge clk);
      rf_we = 1'b0; rf_raddr_b = 5'd5;
      #1 chk("R10 overwrite", rf_rdata_b, 32'h0BAD_F00D);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule